// File: doc/BRIEF.md
# Two-Read Parallel Converter Sample Capture

This block reads conversion results from a fast sigma-delta converter that has a 16-bit parallel output bus. The converter signals a finished conversion with an active-low data-ready strobe. The block brings that strobe into the system clock domain and detects its falling edge. It then holds chip-select low and drives two active-low read strobes. Each strobe's low time, the gap between the two strobes and the point where the bus is sampled are set in system clocks by parameters.

The first bus word holds the top 16 bits of the 24-bit result. The second word carries the bottom result byte in its upper half and a converter status byte in its lower half. The block joins the first word with the upper half of the second word to form a signed two's complement sample, which it presents with a one-cycle valid pulse. The status byte goes to its own output. If a new data-ready edge arrives while a read pair is still running, the edge is ignored and a sticky overrun flag is set; only reset clears it.

Top module: `adc_dual_read_capture`

## Requirements
- R1: The data-ready input passes through a two-flop synchroniser, and only its high-to-low transition starts a read pair. Holding it low for many cycles starts exactly one pair.
- R2: Every accepted data-ready edge produces exactly two read strobe pulses, and chip-select stays low from the start of the first pulse to the end of the second.
- R3: Each read strobe is low for exactly RD_LOW_CYC clocks. The two strobes are separated by exactly RD_HIGH_CYC clocks with chip-select low and the read strobe high.
- R4: The sample output is the first bus word in bits 23:8 followed by bits 15:8 of the second bus word in bits 7:0, taken as signed two's complement (bit 23 is the sign).
- R5: Bits 7:0 of the second bus word appear on the status output and never in the sample.
- R6: Each read pair produces exactly one valid pulse, one clock wide, with the sample and status outputs holding the new values in that cycle.
- R7: A data-ready edge that arrives while a read pair is in progress does not disturb that pair and adds no reads. It sets the overrun flag, which stays set until reset.
- R8: A read pair, from the first strobe until chip-select returns high, lasts fewer than CONV_CYC clocks, the conversion period in system clocks.
- R9: While reset is asserted, chip-select and the read strobe are high and the valid and overrun outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| drdy_n_i | input | 1 | Converter data-ready strobe, active low, asynchronous |
| data_i | input | 16 | Converter parallel data bus |
| cs_n_o | output | 1 | Converter chip-select, active low |
| rd_n_o | output | 1 | Converter read strobe, active low |
| sample_o | output | 24 | Assembled signed sample |
| sample_vld_o | output | 1 | One-cycle pulse marking a new sample |
| status_o | output | 8 | Status byte from the second bus word |
| overrun_o | output | 1 | Sticky flag: data-ready edge arrived during a read pair |

## Verification
The hardest condition to reach is a second data-ready falling edge that lands while the read pair is running. To be seen as an edge, the strobe must go high and low again after the synchroniser delay, yet still before chip-select is released. The bench pulses the strobe low, releases it after two clocks and lowers it again four clocks later, which puts the second edge in the middle of the first read pair. It then checks that the sample is intact, that only two reads were issued and that the flag stays set through a later clean frame until reset. The normal frames hold the strobe low for twenty clocks to show that a held level does not retrigger. Each frame pairs the sample with a status byte chosen to differ from the sample's low byte, so any mixing of the two bytes shows up.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD1  = 2'd1,
    ST_GAP  = 2'd2,
    ST_RD2  = 2'd3
  } rd_state_t;
endpackage

// File: rtl/adcrd_front.sv
// Reset release synchroniser plus data-ready synchroniser and falling-edge detect.
module adcrd_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic drdy_n_i,
  output logic rst_n_o,
  output logic drdy_fall_o
);
  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [1:0]        rst_pipe_q;
  logic [PIPE_W-1:0] drdy_pipe_q;
  logic [PIPE_W-1:0] drdy_pipe_d;

  // reset: asserts at once, releases after two clocks
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_o = rst_pipe_q[1];

  // one extra stage beyond the synchroniser for edge detection
  always_comb begin
    drdy_pipe_d = {drdy_pipe_q[PIPE_W-2:0], drdy_n_i};
  end

  always_ff @(posedge clk or negedge rst_n_o) begin
    if (!rst_n_o) drdy_pipe_q <= '1;
    else          drdy_pipe_q <= drdy_pipe_d;
  end

  assign drdy_fall_o = drdy_pipe_q[PIPE_W-1] & ~drdy_pipe_q[PIPE_W-2];

  // R1
  // the edge detector never reports a held low level twice in a row
  single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n_o)
    drdy_fall_o |=> !drdy_fall_o);
endmodule

// File: rtl/adcrd_rdseq.sv
// Read strobe sequencer: two timed read pulses under one chip-select.
module adcrd_rdseq
  import adcrd_pkg::*;
#(
  parameter int RD_LOW_CYC  = 4,
  parameter int RD_HIGH_CYC = 2,
  parameter int SMP_CYC     = 3,
  parameter int CONV_CYC    = 625
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic cs_n_o,
  output logic rd_n_o,
  output logic cap_hi_o,
  output logic cap_lo_o,
  output logic overrun_o
);
  localparam int CNT_MAX = (RD_LOW_CYC > RD_HIGH_CYC) ? RD_LOW_CYC : RD_HIGH_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] LOW_LAST  = CNT_W'(RD_LOW_CYC - 1);
  localparam logic [CNT_W-1:0] HIGH_LAST = CNT_W'(RD_HIGH_CYC - 1);
  localparam logic [CNT_W-1:0] SMP_AT    = CNT_W'(SMP_CYC);

  rd_state_t        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             rd_n_q, rd_n_d;
  logic             cs_n_q, cs_n_d;
  logic             ovr_q, ovr_d;

  // next-state logic
  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    cap_hi_o = 1'b0;
    cap_lo_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_RD1;
          cnt_d   = '0;
        end
      end
      ST_RD1: begin
        cap_hi_o = (cnt_q == SMP_AT);
        if (cnt_q == LOW_LAST) begin
          state_d = ST_GAP;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_GAP: begin
        if (cnt_q == HIGH_LAST) begin
          state_d = ST_RD2;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_RD2: begin
        cap_lo_o = (cnt_q == SMP_AT);
        if (cnt_q == LOW_LAST) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
    cnt_en = (state_q != ST_IDLE) || start_i;
    rd_n_d = !((state_d == ST_RD1) || (state_d == ST_RD2));
    cs_n_d = (state_d == ST_IDLE);
    ovr_d  = ovr_q | (start_i && (state_q != ST_IDLE));
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rd_n_q  <= 1'b1;
      cs_n_q  <= 1'b1;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rd_n_q  <= rd_n_d;
      cs_n_q  <= cs_n_d;
      ovr_q   <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign rd_n_o    = rd_n_q;
  assign cs_n_o    = cs_n_q;
  assign overrun_o = ovr_q;

  // checker state for the timing properties
  logic [15:0] chk_low_run;
  logic [15:0] chk_busy_run;
  logic [1:0]  chk_reads;
  logic        chk_rd_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_low_run  <= '0;
      chk_busy_run <= '0;
      chk_reads    <= '0;
      chk_rd_prev  <= 1'b1;
    end else begin
      chk_rd_prev  <= rd_n_q;
      chk_low_run  <= rd_n_q ? 16'd0 : chk_low_run + 16'd1;
      chk_busy_run <= cs_n_q ? 16'd0 : chk_busy_run + 16'd1;
      if (cs_n_q)                     chk_reads <= '0;
      else if (!rd_n_q && chk_rd_prev) chk_reads <= chk_reads + 2'd1;
    end
  end

  // R3
  rd_low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n_q) |-> (chk_low_run == 16'(RD_LOW_CYC)));

  // R2
  two_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_q) |-> (chk_reads == 2'd2));

  // R8
  conv_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_busy_run < 16'(CONV_CYC));

  // R7
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> ovr_q);
endmodule

// File: rtl/adcrd_assemble.sv
// Joins the two bus words into the signed sample and splits off status.
module adcrd_assemble #(
  parameter int DATA_W = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cap_hi_i,
  input  logic                             cap_lo_i,
  input  logic [DATA_W-1:0]                data_i,
  output logic signed [DATA_W+DATA_W/2-1:0] sample_o,
  output logic                             valid_o,
  output logic [DATA_W/2-1:0]              status_o
);
  localparam int BYTE_W   = DATA_W / 2;
  localparam int SAMPLE_W = DATA_W + BYTE_W;

  logic [DATA_W-1:0]   hi_q;
  logic [SAMPLE_W-1:0] smp_q, smp_d;
  logic [BYTE_W-1:0]   stat_q, stat_d;
  logic                vld_q;

  always_comb begin
    smp_d  = {hi_q, data_i[DATA_W-1 -: BYTE_W]};
    stat_d = data_i[BYTE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hi_q <= '0;
    else if (cap_hi_i) hi_q <= data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q  <= '0;
      stat_q <= '0;
    end else if (cap_lo_i) begin
      smp_q  <= smp_d;
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= cap_lo_i;
  end

  assign sample_o = $signed(smp_q);
  assign status_o = stat_q;
  assign valid_o  = vld_q;

  // R6
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

  // R5
  status_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_lo_i |=> (status_o == $past(data_i[BYTE_W-1:0])));
endmodule

// File: rtl/adc_dual_read_capture.sv
module adc_dual_read_capture #(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int RD_LOW_CYC  = 4,
  parameter int RD_HIGH_CYC = 2,
  parameter int SMP_CYC     = 3,
  parameter int CONV_CYC    = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        drdy_n_i,
  input  logic [15:0] data_i,
  output logic        cs_n_o,
  output logic        rd_n_o,
  output logic signed [23:0] sample_o,
  output logic        sample_vld_o,
  output logic [7:0]  status_o,
  output logic        overrun_o
);
  logic rst_n_sync;
  logic start;
  logic cap_hi;
  logic cap_lo;

  adcrd_front #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_front (
    .clk        (clk),
    .arst_n     (rst_n),
    .drdy_n_i   (drdy_n_i),
    .rst_n_o    (rst_n_sync),
    .drdy_fall_o(start)
  );

  adcrd_rdseq #(
    .RD_LOW_CYC (RD_LOW_CYC),
    .RD_HIGH_CYC(RD_HIGH_CYC),
    .SMP_CYC    (SMP_CYC),
    .CONV_CYC   (CONV_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .start_i  (start),
    .cs_n_o   (cs_n_o),
    .rd_n_o   (rd_n_o),
    .cap_hi_o (cap_hi),
    .cap_lo_o (cap_lo),
    .overrun_o(overrun_o)
  );

  adcrd_assemble #(
    .DATA_W(DATA_W)
  ) u_asm (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .cap_hi_i(cap_hi),
    .cap_lo_i(cap_lo),
    .data_i  (data_i),
    .sample_o(sample_o),
    .valid_o (sample_vld_o),
    .status_o(status_o)
  );
endmodule

// File: tb/adc_dual_read_capture_test.sv
module adc_dual_read_capture_test;
  localparam int RD_LOW  = 3;
  localparam int RD_HIGH = 2;

  logic        clk;
  logic        rst_n;
  logic        drdy_n;
  logic [15:0] data;
  logic        cs_n, rd_n, vld, ovr;
  logic signed [23:0] sample;
  logic [7:0]  status;

  int checks = 0;
  int fails  = 0;

  adc_dual_read_capture #(
    .RD_LOW_CYC (RD_LOW),
    .RD_HIGH_CYC(RD_HIGH),
    .SMP_CYC    (2),
    .CONV_CYC   (40)
  ) uut (
    .clk(clk), .rst_n(rst_n), .drdy_n_i(drdy_n), .data_i(data),
    .cs_n_o(cs_n), .rd_n_o(rd_n), .sample_o(sample), .sample_vld_o(vld),
    .status_o(status), .overrun_o(ovr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // converter model
  logic [15:0] w_hi, w_lo;
  int rd_seen = 0;
  int rd_base = 0;
  always @(negedge rd_n) rd_seen = rd_seen + 1;
  assign data = rd_n ? 16'hA5A5 : (((rd_seen - rd_base) <= 1) ? w_hi : w_lo);

  // port monitor, sampled on the falling clock edge
  int low_run = 0, width_seen = 0, width_bad = 0, gap_total = 0;
  int vld_cnt = 0, vld_dbl = 0, cs_bad = 0;
  logic vld_prev = 1'b0;
  logic [23:0] got_sample;
  logic [7:0]  got_status;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!rd_n) low_run = low_run + 1;
      else begin
        if (low_run != 0) begin
          width_seen = width_seen + 1;
          if (low_run != RD_LOW) width_bad = width_bad + 1;
        end
        low_run = 0;
      end
      if (!cs_n && rd_n) gap_total = gap_total + 1;
      if (cs_n && !rd_n) cs_bad = cs_bad + 1;
      if (vld) begin
        vld_cnt = vld_cnt + 1;
        got_sample = sample;
        got_status = status;
        if (vld_prev) vld_dbl = vld_dbl + 1;
      end
      vld_prev = vld;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // one conversion; when dbl is set a second edge hits mid-sequence
  task automatic frame(input logic [23:0] s, input logic [7:0] st, input bit dbl);
    int v0, ws0, wb0, g0, d0;
    int exp_val;
    rd_base = rd_seen;
    w_hi = s[23:8];
    w_lo = {s[7:0], st};
    v0 = vld_cnt; ws0 = width_seen; wb0 = width_bad; g0 = gap_total; d0 = vld_dbl;
    @(negedge clk) drdy_n = 1'b0;
    if (dbl) begin
      repeat (2) @(negedge clk);
      drdy_n = 1'b1;
      repeat (4) @(negedge clk);
      drdy_n = 1'b0;
    end
    repeat (20) @(negedge clk);
    drdy_n = 1'b1;
    repeat (10) @(negedge clk);
    exp_val = s[23] ? (int'(s) - (1 << 24)) : int'(s);
    chk(rd_seen - rd_base == 2, "R2 reads per edge (R1 level held)", rd_seen - rd_base, 2);
    chk(vld_cnt - v0 == 1, "R6 valid pulses", vld_cnt - v0, 1);
    chk(vld_dbl == d0, "R6 valid width", vld_dbl - d0, 0);
    chk($signed(got_sample) == exp_val, "R4 sample", $signed(got_sample), exp_val);
    chk(got_status == st, "R5 status", got_status, st);
    chk(width_seen - ws0 == 2 && width_bad == wb0, "R3 strobe low width",
        width_bad - wb0, 0);
    chk(gap_total - g0 == RD_HIGH, "R3 strobe gap", gap_total - g0, RD_HIGH);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    logic [23:0] lfsr;
    w_hi = '0; w_lo = '0;
    drdy_n = 1'b1;
    rst_n  = 1'b0;
    repeat (4) @(negedge clk);
    // R9 reset state
    chk(cs_n && rd_n && !vld && !ovr, "R9 reset outputs", {cs_n, rd_n, vld, ovr}, 4'b1100);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    for (int b = 0; b < 24; b++) begin
      logic [23:0] s;
      s = 24'd1 << b;
      frame(s, ~s[7:0] ^ 8'(b), 1'b0);
    end
    frame(24'h000000, 8'hFF, 1'b0);
    frame(24'hFFFFFF, 8'h00, 1'b0);
    frame(24'h7FFFFF, 8'h80, 1'b0);
    frame(24'h800000, 8'h7F, 1'b0);
    frame(24'hFFFF00, 8'hC3, 1'b0);
    lfsr = 24'hACE1F0;
    for (int k = 0; k < 32; k++) begin
      lfsr = {lfsr[22:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
      frame(lfsr, lfsr[15:8] ^ 8'h5A, 1'b0);
    end
    chk(cs_bad == 0, "R2 chip-select covers reads", cs_bad, 0);
    // R7 overrun
    chk(!ovr, "R7 no overrun before collision", ovr, 0);
    frame(24'h3C5A96, 8'h11, 1'b1);
    chk(ovr, "R7 overrun raised", ovr, 1);
    frame(24'hC0FFEE, 8'h22, 1'b0);
    chk(ovr, "R7 overrun sticky", ovr, 1);
    // R9 reset clears
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    chk(cs_n && rd_n && !vld && !ovr, "R9 reset clears", {cs_n, rd_n, vld, ovr}, 4'b1100);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    frame(24'h123456, 8'h9A, 1'b0);
    chk(!ovr, "R7 overrun stays clear", ovr, 0);
    finish_up();
  end
endmodule